// File: doc/BRIEF.md
# Sequential LU Factorisation Engine

This block splits a small square matrix A into a unit-lower-triangular factor L and an upper-triangular factor U, so that A = L·U. It does not pivot. A clocked state machine steps through the three nested loops of the elimination one operation per step. It uses one shared multiply-subtract datapath and one restoring divider that produces one quotient bit per cycle. All entries are signed Q8.8 fixed point: 16 bits, with 8 of them fractional.

Software or a neighbouring block first writes the matrix one entry per cycle through an indexed write port. It then pulses `start`. The engine raises `busy` while it runs. At the end it pulses `done`, or it pulses `err` if a diagonal pivot is found to be zero. L and U then stay readable through a combinational indexed read port until the next start.

The working matrix is overwritten in place during a run, so a fresh matrix must be written before each start. The write, read and start pins are plain register-style controls, not valid/ready streams. Data moves only while the engine is idle, so there is no back-pressure: a write made while `busy` is high is dropped.

Top module: `lu_engine`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and every L and U read returns 0.
- R2: `start` is acted on only when idle. `busy` goes high in the cycle after an accepted start and stays high until the cycle in which `done` or `err` pulses. A `start` seen while busy has no effect on timing or results.
- R3: For each pivot step k that passes the zero test, L(k,k) becomes exactly 1.0 (0x0100) and U(k,k) becomes the working value X(k,k).
- R4: For each row i > k, L(i,k) is X(i,k)·256 / X(k,k), with the quotient truncated toward zero and saturated to the range 0x8000..0x7FFF. All multipliers of column k are computed before any update of step k.
- R5: For each i > k, U(k,i) is a copy of the working value X(k,i).
- R6: For i,j > k, X(i,j) becomes X(i,j) − P, where P is L(i,k)·U(k,j) shifted right by 8 with rounding toward negative infinity and then saturated to 16 bits. The difference is saturated to 16 bits as well.
- R7: If X(k,k) is zero at the start of step k, the engine stops at once and pulses `err` instead of `done`. Entries from steps that were not reached stay 0.
- R8: An accepted start clears all of L and U. L above the diagonal and U below the diagonal are always read as 0.
- R9: `done` and `err` are single-cycle pulses and never high together. The results hold unchanged after the pulse until the next start.
- R10: Matrix writes made while busy are ignored.
- R11: A run that completes takes T = Σ over k from 0 to N−1 of [1 + (N−1−k)·26 + (N−1−k)²] busy cycles. A run that fails at step k takes the same sum for the steps before k, plus 1.
- R12: Read select 0 returns L and read select 1 returns U, indexed by row and column from 0. An index of N or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one entry of the input matrix (idle only) |
| wr_row | input | 2 | Write row index |
| wr_col | input | 2 | Write column index |
| wr_data | input | 16 | Q8.8 entry to write |
| start | input | 1 | Begin factorisation |
| rd_sel | input | 1 | 0 selects L, 1 selects U |
| rd_row | input | 2 | Read row index |
| rd_col | input | 2 | Read column index |
| rd_data | output | 16 | Selected Q8.8 entry (combinational) |
| busy | output | 1 | Factorisation in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on a zero pivot |

## Verification
The bench checks four failure cases, and each one shows a distinct symptom if the design gets it wrong:
- **Zero pivot.** The matrix [[1,2,2],[3,4,4],[5,6,6]] only produces a zero pivot at the third step, and a matrix with a zero first pivot fails at once. A design that tests the pivot too late would divide by zero and pulse `done`. A design that forgets to clear L and U would leave stale entries from the previous run.
- **Saturation and rounding.** Large operands push both the quotient and the product into saturation, and negative fractional operands expose rounding. A wrong rounding direction in the divider or the multiplier shows up in the low bits of L or U.
- **Row wrap.** A design that restarts the inner column index at a fixed value instead of at k+1 corrupts the step-2 update.
- **Busy behaviour.** A write and a start injected mid-run must change neither the timing nor the result. The latency is compared on every clock against the cycle formula.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PIVOT,
    ST_DIVS,
    ST_DIVW,
    ST_UPD
  } lu_state_t;

  typedef enum logic {
    SEL_L = 1'b0,
    SEL_U = 1'b1
  } lu_sel_t;

endpackage

// File: rtl/lu_div.sv
// Signed Q-format restoring divider: quotient = num * 2^FRAC / den,
// truncated toward zero, saturated to W bits. One quotient bit per cycle.
module lu_div #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                done,
  output logic signed [W-1:0] quot
);
  localparam int DW = W + FRAC;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);
  localparam logic [DW-1:0] POS_LIM   = DW'((2 ** (W - 1)) - 1);
  localparam logic [DW-1:0] NEG_LIM   = DW'(2 ** (W - 1));

  logic [W-1:0]  rem_q, dmag_q;
  logic [DW-1:0] dvd_q, quo_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q, busy_q, done_q;

  logic [W-1:0] num_mag, den_mag;
  logic [W:0]   trial, trial_sub;
  logic         ge;

  assign num_mag   = num[W-1] ? (~num + 1'b1) : num;
  assign den_mag   = den[W-1] ? (~den + 1'b1) : den;
  assign trial     = {rem_q, dvd_q[DW-1]};
  assign ge        = trial >= {1'b0, dmag_q};
  assign trial_sub = trial - {1'b0, dmag_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dmag_q <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      neg_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        rem_q  <= '0;
        dmag_q <= den_mag;
        dvd_q  <= {num_mag, {FRAC{1'b0}}};
        quo_q  <= '0;
        cnt_q  <= '0;
        neg_q  <= num[W-1] ^ den[W-1];
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? trial_sub[W-1:0] : trial[W-1:0];
        dvd_q <= {dvd_q[DW-2:0], 1'b0};
        quo_q <= {quo_q[DW-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_STEP) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (neg_q) begin
      if (quo_q >= NEG_LIM) quot = {1'b1, {(W-1){1'b0}}};
      else                  quot = ~quo_q[W-1:0] + 1'b1;
    end else begin
      if (quo_q > POS_LIM)  quot = {1'b0, {(W-1){1'b1}}};
      else                  quot = quo_q[W-1:0];
    end
  end

  assign done = done_q;

  a_r4_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/lu_mac.sv
// res = sat(acc - sat(floor(a*b / 2^FRAC)))
module lu_mac #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic signed [W-1:0] acc,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] res
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] P_MAX = PW'((2 ** (W - 1)) - 1);
  localparam logic signed [PW-1:0] P_MIN = -P_MAX - 1;
  localparam logic signed [W:0]    D_MAX = (W+1)'((2 ** (W - 1)) - 1);
  localparam logic signed [W:0]    D_MIN = -D_MAX - 1;

  logic signed [PW-1:0] a_x, b_x, prod, prod_sh;
  logic signed [W-1:0]  prod_sat;
  logic signed [W:0]    diff;

  assign a_x     = PW'(a);
  assign b_x     = PW'(b);
  assign prod    = a_x * b_x;
  assign prod_sh = prod >>> FRAC;

  always_comb begin
    if (prod_sh > P_MAX)      prod_sat = P_MAX[W-1:0];
    else if (prod_sh < P_MIN) prod_sat = P_MIN[W-1:0];
    else                      prod_sat = prod_sh[W-1:0];
  end

  assign diff = {acc[W-1], acc} - {prod_sat[W-1], prod_sat};

  always_comb begin
    if (diff > D_MAX)      res = D_MAX[W-1:0];
    else if (diff < D_MIN) res = D_MIN[W-1:0];
    else                   res = diff[W-1:0];
  end

endmodule

// File: rtl/lu_engine.sv
module lu_engine
  import lu_pkg::*;
#(
  parameter int N    = 3,
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_row,
  input  logic [IW-1:0] wr_col,
  input  logic [W-1:0]  wr_data,
  input  logic          start,
  input  logic          rd_sel,
  input  logic [IW-1:0] rd_row,
  input  logic [IW-1:0] rd_col,
  output logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [IW-1:0]       LAST = IW'(N - 1);
  localparam logic [IW:0]         NV   = (IW+1)'(N);
  localparam logic signed [W-1:0] ONE  = W'(2 ** FRAC);

  lu_state_t st_q;
  logic [IW-1:0] k_q, i_q, j_q;
  logic done_q, err_q;

  logic signed [W-1:0] x_q [N][N];
  logic signed [W-1:0] l_q [N][N];
  logic signed [W-1:0] u_q [N][N];

  logic                dv_start, dv_done;
  logic signed [W-1:0] dv_quot, mac_res;
  logic                wr_ok, rd_ok;

  assign dv_start = (st_q == ST_DIVS);

  lu_div #(.W(W), .FRAC(FRAC)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .start(dv_start),
    .num  (x_q[i_q][k_q]),
    .den  (x_q[k_q][k_q]),
    .done (dv_done),
    .quot (dv_quot)
  );

  lu_mac #(.W(W), .FRAC(FRAC)) u_mac (
    .acc(x_q[i_q][j_q]),
    .a  (l_q[i_q][k_q]),
    .b  (u_q[k_q][j_q]),
    .res(mac_res)
  );

  assign wr_ok = wr_en && ({1'b0, wr_row} < NV) && ({1'b0, wr_col} < NV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      i_q    <= '0;
      j_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          x_q[r][c] <= '0;
          l_q[r][c] <= '0;
          u_q[r][c] <= '0;
        end
      end
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (wr_ok) x_q[wr_row][wr_col] <= wr_data;
          if (start) begin
            for (int r = 0; r < N; r++) begin
              for (int c = 0; c < N; c++) begin
                l_q[r][c] <= '0;
                u_q[r][c] <= '0;
              end
            end
            k_q  <= '0;
            st_q <= ST_PIVOT;
          end
        end
        ST_PIVOT: begin
          if (x_q[k_q][k_q] == '0) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            u_q[k_q][k_q] <= x_q[k_q][k_q];
            l_q[k_q][k_q] <= ONE;
            if (k_q == LAST) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              i_q  <= k_q + 1'b1;
              st_q <= ST_DIVS;
            end
          end
        end
        ST_DIVS: begin
          u_q[k_q][i_q] <= x_q[k_q][i_q];
          st_q          <= ST_DIVW;
        end
        ST_DIVW: begin
          if (dv_done) begin
            l_q[i_q][k_q] <= dv_quot;
            if (i_q == LAST) begin
              i_q  <= k_q + 1'b1;
              j_q  <= k_q + 1'b1;
              st_q <= ST_UPD;
            end else begin
              i_q  <= i_q + 1'b1;
              st_q <= ST_DIVS;
            end
          end
        end
        ST_UPD: begin
          x_q[i_q][j_q] <= mac_res;
          if (j_q == LAST) begin
            j_q <= k_q + 1'b1;
            if (i_q == LAST) begin
              k_q  <= k_q + 1'b1;
              st_q <= ST_PIVOT;
            end else begin
              i_q <= i_q + 1'b1;
            end
          end else begin
            j_q <= j_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_ok = ({1'b0, rd_row} < NV) && ({1'b0, rd_col} < NV);

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      if (lu_sel_t'(rd_sel) == SEL_U) rd_data = u_q[rd_row][rd_col];
      else                            rd_data = l_q[rd_row][rd_col];
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;

  a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == ST_IDLE) |=> busy);
  a_r7_err_from_zero_pivot: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(st_q == ST_PIVOT) && $past(x_q[k_q][k_q] == '0)));
  a_r3_diag_one: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PIVOT && x_q[k_q][k_q] != '0) |=> (l_q[k_q][k_q] == ONE));
  a_r4_div_before_update: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_UPD) |-> !dv_done);

endmodule

// File: tb/lu_engine_tb.sv
module lu_engine_tb;
  localparam int N    = 3;
  localparam int W    = 16;
  localparam int FRAC = 8;
  localparam int IW   = 2;
  localparam int DW   = W + FRAC;
  localparam int ONE  = 1 << FRAC;
  localparam int VMAX = 32767;
  localparam int VMIN = -32768;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_row = '0, wr_col = '0;
  logic [W-1:0]  wr_data = '0;
  logic          start = 1'b0;
  logic          rd_sel = 1'b0;
  logic [IW-1:0] rd_row = '0, rd_col = '0;
  logic [W-1:0]  rd_data;
  logic          busy, done, err;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int m_in  [N][N];
  int exp_l [N][N];
  int exp_u [N][N];
  int exp_t;
  bit exp_err;

  always #2 clk = ~clk;

  lu_engine #(.N(N), .W(W), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .start(start), .rd_sel(rd_sel), .rd_row(rd_row),
    .rd_col(rd_col), .rd_data(rd_data), .busy(busy), .done(done), .err(err)
  );

  function automatic int sat(int v);
    if (v > VMAX) return VMAX;
    if (v < VMIN) return VMIN;
    return v;
  endfunction

  function automatic int div_q(int a, int b);
    int q;
    q = (a * ONE) / b;
    return sat(q);
  endfunction

  function automatic int mul_fl(int a, int b);
    int p;
    p = (a * b) >>> FRAC;
    return sat(p);
  endfunction

  task automatic check(string req, int act, int expv, string what);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model_run();
    int  x[N][N];
    bit  stop;
    stop    = 0;
    exp_err = 0;
    exp_t   = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        x[r][c] = m_in[r][c]; exp_l[r][c] = 0; exp_u[r][c] = 0;
      end
    for (int k = 0; k < N; k++) begin
      if (!stop) begin
        exp_t++;
        if (x[k][k] == 0) begin
          exp_err = 1; stop = 1;
        end else begin
          exp_u[k][k] = x[k][k];
          exp_l[k][k] = ONE;
          for (int i = k + 1; i < N; i++) begin
            exp_l[i][k] = div_q(x[i][k], x[k][k]);
            exp_u[k][i] = x[k][i];
            exp_t += DW + 2;
          end
          for (int i = k + 1; i < N; i++)
            for (int j = k + 1; j < N; j++) begin
              x[i][j] = sat(x[i][j] - mul_fl(exp_l[i][k], exp_u[k][j]));
              exp_t++;
            end
        end
      end
    end
  endtask

  task automatic load_matrix();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(c); wr_data = W'(m_in[r][c]);
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2/R9/R10/R11: compare busy/done/err with the model on every clock
  task automatic launch(bit disturb);
    model_run();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int m = 0; m <= exp_t + 1; m++) begin
      check("R11", int'(busy), int'(m < exp_t), $sformatf("busy at cycle %0d", m));
      check("R9", int'(done), int'(m == exp_t && !exp_err), $sformatf("done at cycle %0d", m));
      check("R7", int'(err), int'(m == exp_t && exp_err), $sformatf("err at cycle %0d", m));
      if (disturb && m == 5) begin
        // R10 and R2: write and start while busy must be ignored
        wr_en = 1'b1; wr_row = 2'd2; wr_col = 2'd2; wr_data = 16'h7000; start = 1'b1;
      end
      if (disturb && m == 6) begin
        wr_en = 1'b0; start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic read_all(string req);
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          rd_sel = s[0]; rd_row = IW'(r); rd_col = IW'(c);
          #1;
          check(req, int'($signed(rd_data)), (s == 0) ? exp_l[r][c] : exp_u[r][c],
                $sformatf("%s(%0d,%0d)", (s == 0) ? "L" : "U", r, c));
        end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(busy), 0, "busy after reset");
    check("R1", int'(done), 0, "done after reset");
    check("R1", int'(err), 0, "err after reset");
    for (int i = 0; i < N; i++) begin exp_l[i] = '{0, 0, 0}; exp_u[i] = '{0, 0, 0}; end
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R1");

    // R12 out-of-range read returns zero
    rd_sel = 1'b1; rd_row = 2'd3; rd_col = 2'd0; #1;
    check("R12", int'(rd_data), 0, "out-of-range read");

    // R7/R3/R4/R5: third pivot zero
    m_in = '{'{256, 512, 512}, '{768, 1024, 1024}, '{1280, 1536, 1536}};
    load_matrix(); launch(0); read_all("R7");
    check("R4", exp_l[2][1], 512, "model L(2,1)");

    // R3/R4/R6: nonsingular, exact
    m_in = '{'{1024, 768, 512}, '{512, 1280, 256}, '{1536, 256, 1792}};
    load_matrix(); launch(0); read_all("R6");
    // R9: results hold after the pulse
    repeat (5) @(negedge clk);
    read_all("R9");

    // R4/R6: negative fractional values, truncation and floor
    m_in = '{'{768, -256, 384}, '{-512, 640, 100}, '{333, -77, 900}};
    load_matrix(); launch(0); read_all("R4");

    // R4/R6: saturation of quotient and product
    m_in = '{'{64, 30000, -30000}, '{32767, -32768, 1000}, '{-32768, 500, 200}};
    load_matrix(); launch(0); read_all("R6");

    // R8/R7: first pivot zero after a full run, everything cleared
    m_in = '{'{0, 256, 256}, '{256, 256, 256}, '{256, 512, 768}};
    load_matrix(); launch(0); read_all("R8");

    // R10/R2: write and start during busy ignored
    m_in = '{'{1024, 768, 512}, '{512, 1280, 256}, '{1536, 256, 1792}};
    load_matrix(); launch(1); read_all("R10");

    finished = 1;
    summary();
    $finish;
  end

endmodule